// File: doc/BRIEF.md
# Pin Bank with Half-Word Masked Output Writes

This block is one bank of general-purpose pins, up to 32 wide, driven through a plain 32-bit register port (address, write strobe, write word, read strobe, read word). Each pin has a direction bit, an output-enable bit and an output data bit. A pin is driven only when its direction bit and its enable bit are both set. A separate read-only location returns the levels actually present on the pins. That value can differ from what the bank is trying to drive.

Two write-only half-word locations let software change any subset of the output bits in a single store, with no read-modify-write. One location covers pins 0 to 15 and the other covers pins 16 to 31. In each word, bits 31:16 are a keep mask and bits 15:0 are the new data. A data bit is applied only where its mask bit is 0. Tri-state pads and input synchronizers sit outside the block: the pads appear as the `pin_out`/`pin_oe` ports and the synchronized levels come in on `pin_in`.

Top module: `gpio_mask_bank`

## Requirements
- R1: A write to offset 0x040 loads the output data register, which drives `pin_out` from the next cycle and reads back at 0x040.
- R2: A write to offset 0x000 updates pin b (b = 0..15) to wr_data[b] only where wr_data[16+b] is 0. All other output bits, including pins 16 and up, keep their values.
- R3: A write to offset 0x004 updates pin 16+k to wr_data[k] only where wr_data[16+k] is 0. Pins 0 to 15 keep their values.
- R4: The direction register at 0x204 and the output-enable register at 0x208 can be written and read back. A direction bit of 1 means output.
- R5: `pin_oe[i]` is high exactly when direction bit i and output-enable bit i are both 1.
- R6: A read of offset 0x060 returns the value of `pin_in` sampled on the read cycle. Writes to 0x060 change nothing.
- R7: Bits at or above NPINS read as 0 in every register, and writes to those bits are dropped.
- R8: While `rst_n` is low, the direction, output-enable and output data registers are all 0, and so is `rd_data`.
- R9: Reads of 0x000, 0x004 and of any unmapped offset return 0.
- R10: `rd_data` is updated on the clock edge where `rd_en` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte offset within the bank window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read word |
| pin_in | input | NPINS | Synchronized pin levels |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Per-pin drive enable to the pads |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high for the same offset in the same cycle. They also assume that `pin_in` is stable at the clock edge, since it comes from synchronizers outside the block. The bench drives every input on the falling edge and issues a single access per cycle, so both conditions always hold. The bench builds the bank with 22 pins so that the upper masked half is only partly populated. Random words sweep every register against a shadow model kept in the bench.

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam logic [31:0] LIVE = (NPINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NPINS) - 32'd1);
  localparam logic [AW-1:0] A_MLO  = AW'('h000);
  localparam logic [AW-1:0] A_MHI  = AW'('h004);
  localparam logic [AW-1:0] A_OUT  = AW'('h040);
  localparam logic [AW-1:0] A_PINS = AW'('h060);
  localparam logic [AW-1:0] A_DIR  = AW'('h204);
  localparam logic [AW-1:0] A_OEN  = AW'('h208);

  logic [31:0] out_q, dir_q, oen_q;
  logic [31:0] pin_ext, keep_lo, keep_hi, lo_merge, hi_merge;

  assign pin_ext  = 32'(pin_in) & LIVE;
  assign keep_lo  = {16'hFFFF, wr_data[31:16]};
  assign keep_hi  = {wr_data[31:16], 16'hFFFF};
  assign lo_merge = (out_q & keep_lo) | ({16'h0, wr_data[15:0]} & ~keep_lo);
  assign hi_merge = (out_q & keep_hi) | ({wr_data[15:0], 16'h0} & ~keep_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      oen_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MLO:   out_q <= lo_merge & LIVE;
        A_MHI:   out_q <= hi_merge & LIVE;
        A_OUT:   out_q <= wr_data & LIVE;
        A_DIR:   dir_q <= wr_data & LIVE;
        A_OEN:   oen_q <= wr_data & LIVE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        A_OUT:   rd_data <= out_q;
        A_PINS:  rd_data <= pin_ext;
        A_DIR:   rd_data <= dir_q;
        A_OEN:   rd_data <= oen_q;
        default: rd_data <= '0;
      endcase
    end
  end

  assign pin_out = out_q[NPINS-1:0];
  assign pin_oe  = dir_q[NPINS-1:0] & oen_q[NPINS-1:0];

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_OUT |=> 32'(pin_out) == ($past(wr_data) & LIVE)); // R1
  AST_LO_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_MLO |=> $stable(32'(pin_out) >> 16)); // R2
  AST_LO_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_MLO && wr_data[31:16] == 16'hFFFF |=> $stable(pin_out)); // R2
  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_MHI |=> $stable(32'(pin_out) & 32'h0000_FFFF)); // R3
  AST_INPUT_MODE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_DIR && wr_data == 32'h0 |=> pin_oe == '0); // R5
  AST_PIN_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == A_PINS |=> rd_data == ($past(32'(pin_in)) & LIVE)); // R6
  AST_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data & ~LIVE) == 32'h0); // R7
  AST_MASKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == A_MLO || addr == A_MHI) |=> rd_data == 32'h0); // R9
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

// File: tb/gpio_mask_bank_test.sv
`timescale 1ns/1ps
module gpio_mask_bank_test;
  localparam int NP = 22;
  localparam logic [31:0] LIVE = (32'd1 << NP) - 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;

  int checks = 0, fails = 0;
  logic [31:0] mo = '0, md = '0, me = '0, seed = 32'h1234_5678;

  always #10 clk = ~clk;

  gpio_mask_bank #(.NPINS(NP), .AW(12)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    chk({tag, " R1 pin_out"}, 32'(pin_out), mo);
    chk({tag, " R5 pin_oe"}, 32'(pin_oe), md & me);
    rd(12'h040, v); chk({tag, " R1 R7 out readback"}, v, mo);
    rd(12'h204, v); chk({tag, " R4 dir readback"}, v, md);
    rd(12'h208, v); chk({tag, " R4 oen readback"}, v, me);
  endtask

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    chk("R8 pin_out in reset", 32'(pin_out), 0);
    chk("R8 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    check_all("R8 after reset");

    for (int i = 0; i < 300; i++) begin
      seed = nxt(seed); w = seed;
      case (i % 6)
        0: begin wr(12'h040, w); mo = w & LIVE; end
        1: begin
          wr(12'h000, w);
          for (int b = 0; b < 16; b++) if (!w[16+b]) mo[b] = w[b];
          mo &= LIVE;
        end
        2: begin
          wr(12'h004, w);
          for (int k = 0; k < 16; k++) if (!w[16+k]) mo[16+k] = w[k];
          mo &= LIVE;
        end
        3: begin wr(12'h204, w); md = w & LIVE; end
        4: begin wr(12'h208, w); me = w & LIVE; end
        default: begin
          wr(12'h060, w);
          pin_in = NP'(nxt(w));
          rd(12'h060, v); chk("R6 pin level read", v, 32'(pin_in));
        end
      endcase
      check_all($sformatf("sweep %0d R2 R3", i));
      if (i % 25 == 0) begin
        rd(12'h000, v); chk("R9 lower masked reads 0", v, 0);
        rd(12'h004, v); chk("R9 upper masked reads 0", v, 0);
        rd(12'h13C, v); chk("R9 unmapped reads 0", v, 0);
      end
    end

    wr(12'h040, 32'h0015_A5A5); mo = 32'h0015_A5A5;
    wr(12'h000, 32'hFFFF_0000);
    chk("R2 fully masked lower write", 32'(pin_out), mo);
    wr(12'h004, 32'h0000_003F); mo[21:16] = 6'h3F;
    chk("R3 upper write to top pins", 32'(pin_out), mo);
    wr(12'h040, 32'hFFFF_FFFF); mo = LIVE;
    rd(12'h040, v); chk("R7 bits above pin count", v, LIVE);
    wr(12'h204, 32'h0); md = 0;
    chk("R5 inputs never driven", 32'(pin_oe), 0);

    @(negedge clk); addr = 12'h040;
    rd(12'h204, v);
    repeat (2) @(negedge clk);
    chk("R10 rd_data holds without rd_en", rd_data, v);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule